// File: doc/BRIEF.md
# Masked Configuration Space Register File

This block is the 256-byte configuration space of one bus function. A slot-side port presents a register number, an access size, write data and a strobe. The block serves the access one byte per clock, starting at the given register and moving to the next register number each clock. The register number wraps from 0xFF to 0x00. A single `cfg_done` pulse marks the end of the access, and for reads `cfg_rdata` holds the gathered bytes at that point.

Each byte has a write mask fixed at build time. A written byte keeps its old bits where the mask is 0 and takes the new bits where the mask is 1. Bytes with an all-zero mask behave as constants. The space contains:
- identification words,
- a command word with a few writable enables,
- a read-only status word,
- class and revision bytes,
- two address windows, whose alignment follows only from their masks,
- an interrupt-line byte that reads as "none".

An optional counter register advances each time its lowest byte is read. When an access writes any byte of the first address window, the block raises a pulse together with the new window base, so a decoder elsewhere can move the window.

Top module: `cfg_space_regfile`

## Requirements
- R1: A byte write stores (new AND mask) OR (old AND NOT mask); all bytes not listed in R4 to R8 have a zero mask and read 0.
- R2: `cfg_size` 0 is a byte, 1 a word, 2 or 3 a dword. Byte lane i of `cfg_wdata`/`cfg_rdata` (bits 8i+7..8i) maps to register `cfg_reg`+i modulo 256. Lanes above the access size read 0.
- R3: An access of n bytes accepted at a clock edge raises `cfg_done` for exactly one cycle after n further edges. `cfg_busy` is high in between. Strobes seen while busy are ignored.
- R4: Registers 0x00–0x01 hold VENDOR_ID and 0x02–0x03 hold DEVICE_ID (little-endian), and both are read-only.
- R5: The command word at 0x04 resets to CMD_RESET (default 0x0002) and has write mask CMD_MASK (default 0x0403).
- R6: The status word at 0x06 reads STATUS_RESET (default 0x0080). Register 0x3C reads 0xFF. Registers 0x08–0x0B read CLASS_REV (default 0x04000002). All of these are read-only.
- R7: Window 0 at 0x10 has mask 0xFF000000 and resets to (BAR0_BASE AND 0xFFFFFFF0) OR 0x8. Bits 3:0 always read 0x8.
- R8: Window 1 at 0x14 has mask 0xFFFF0000 and resets to BAR1_BASE AND 0xFFFFFFF0.
- R9: A write access that touches any of 0x10–0x13 raises `bar_upd` once, in the same cycle as `cfg_done`. `bar_base` then carries the new window-0 value with bits 3:0 cleared. Reads and writes elsewhere leave `bar_upd` low.
- R10: With HAS_TICK_CTR=1, each byte read of 0x54 increments a 16-bit up-counter and decrements a 16-bit down-counter, both from 0 at reset. The returned byte is taken after the update. The dword at 0x54 is {4'h0, down[11:0], up[15:0]}.
- R11: Reads of 0x55–0x57 return the current counter bytes without advancing either counter. Writes to 0x54–0x57 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Access strobe, taken when not busy |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_reg | input | 8 | First register number of the access |
| cfg_size | input | 2 | Access size code |
| cfg_wdata | input | 32 | Write data, lane i for register+i |
| cfg_busy | output | 1 | Access in progress |
| cfg_done | output | 1 | One-cycle end-of-access pulse |
| cfg_rdata | output | 32 | Read data, valid with cfg_done |
| bar_upd | output | 1 | Window-0 write pulse |
| bar_base | output | 32 | Window-0 base, bits 3:0 zero |

## Verification
The first byte operation happens at the edge that follows the accepting edge. `cfg_done`, `cfg_rdata` and `bar_upd` appear after edge n, where n is 1, 2 or 4 bytes. `cfg_busy` rises one edge after acceptance. Every bench access counts falling edges from the accepting edge until `cfg_done` and checks that count against n. Data and `bar_upd` are sampled on that same falling edge. Because a counter read advances the counter during the low-byte operation, the bench keeps its own counter model and predicts both the post-update value and the later bytes of the same dword read.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } acc_size_e;

    localparam logic [7:0] OFS_IDS      = 8'h00;
    localparam logic [7:0] OFS_CMD      = 8'h04;
    localparam logic [7:0] OFS_CLASS    = 8'h08;
    localparam logic [7:0] OFS_WIN0     = 8'h10;
    localparam logic [7:0] OFS_WIN1     = 8'h14;
    localparam logic [7:0] OFS_IRQ_LINE = 8'h3C;
    localparam logic [7:0] OFS_TICK     = 8'h54;

    localparam int TICK_W    = 16;
    localparam int DOWN_KEEP = 12;

    // one byte operation issued by the sequencer
    typedef struct packed {
        logic       we;
        logic       re;
        logic [7:0] addr;
        logic [7:0] wdata;
    } byte_op_t;

    function automatic logic [1:0] last_lane(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 2'd0;
            SZ_WORD: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [7:0] lane_of(logic [31:0] w, logic [1:0] lane);
        return w[{lane, 3'b000} +: 8];
    endfunction

    function automatic logic same_dword(logic [7:0] a, logic [7:0] base);
        return a[7:2] == base[7:2];
    endfunction

    // byte of a dword value placed at base, zero outside that dword
    function automatic logic [7:0] dword_byte(logic [7:0] a, logic [7:0] base,
                                              logic [31:0] val);
        return same_dword(a, base) ? lane_of(val, a[1:0]) : 8'h00;
    endfunction

endpackage

// File: rtl/cfgsp_sequencer.sv
module cfgsp_sequencer
    import cfgsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [7:0]  acc_reg,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output byte_op_t    op,
    input  logic [7:0]  op_rdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rdata,
    output logic        win0_touch
);

    logic        busy_q, done_q, write_q, touch_acc_q, touch_q;
    logic [1:0]  lane_q, last_q;
    logic [7:0]  base_q;
    logic [31:0] wdata_q, rdata_q;
    logic [7:0]  cur_addr;
    logic        cur_win0;

    assign cur_addr = base_q + {6'd0, lane_q};
    assign cur_win0 = same_dword(cur_addr, OFS_WIN0);

    always_comb begin
        op.we    = busy_q && write_q;
        op.re    = busy_q && !write_q;
        op.addr  = cur_addr;
        op.wdata = lane_of(wdata_q, lane_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            done_q      <= 1'b0;
            write_q     <= 1'b0;
            touch_acc_q <= 1'b0;
            touch_q     <= 1'b0;
            lane_q      <= 2'd0;
            last_q      <= 2'd0;
            base_q      <= 8'h00;
            wdata_q     <= '0;
            rdata_q     <= '0;
        end else begin
            done_q  <= 1'b0;
            touch_q <= 1'b0;
            if (!busy_q) begin
                if (acc_valid) begin
                    busy_q      <= 1'b1;
                    write_q     <= acc_write;
                    base_q      <= acc_reg;
                    wdata_q     <= acc_wdata;
                    lane_q      <= 2'd0;
                    last_q      <= last_lane(acc_size_e'(acc_size));
                    rdata_q     <= '0;
                    touch_acc_q <= 1'b0;
                end
            end else begin
                if (!write_q)
                    rdata_q[{lane_q, 3'b000} +: 8] <= op_rdata;
                if (lane_q == last_q) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    touch_q <= write_q && (touch_acc_q || cur_win0);
                end else begin
                    lane_q      <= lane_q + 2'd1;
                    touch_acc_q <= touch_acc_q || (write_q && cur_win0);
                end
            end
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign rdata      = rdata_q;
    assign win0_touch = touch_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);                                       // R3
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !busy_q) |=> busy_q);                        // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);                                       // R3

endmodule

// File: rtl/cfgsp_byte_store.sv
module cfgsp_byte_store
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'hABCD,
    parameter logic [15:0] DEVICE_ID    = 16'h0042,
    parameter logic [15:0] CMD_RESET    = 16'h0002,
    parameter logic [15:0] CMD_MASK     = 16'h0403,
    parameter logic [15:0] STATUS_RESET = 16'h0080,
    parameter logic [31:0] CLASS_REV    = 32'h0400_0002,
    parameter logic [31:0] BAR0_BASE    = 32'hD000_0000,
    parameter logic [31:0] BAR0_MASK    = 32'hFF00_0000,
    parameter logic [31:0] BAR1_BASE    = 32'hE100_0000,
    parameter logic [31:0] BAR1_MASK    = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  byte_op_t    op,
    output logic [7:0]  rd_byte,
    output logic [31:0] win0_value
);

    localparam int          SPACE_BYTES = 256;
    localparam logic [31:0] WIN0_INIT   = (BAR0_BASE & 32'hFFFF_FFF0) | 32'h8;
    localparam logic [31:0] WIN1_INIT   = BAR1_BASE & 32'hFFFF_FFF0;

    logic [7:0] mem [SPACE_BYTES];

    function automatic logic [7:0] mask_at(logic [7:0] a);
        return dword_byte(a, OFS_CMD,  {16'h0000, CMD_MASK})
             | dword_byte(a, OFS_WIN0, BAR0_MASK & 32'hFFFF_FFF0)
             | dword_byte(a, OFS_WIN1, BAR1_MASK & 32'hFFFF_FFF0);
    endfunction

    function automatic logic [7:0] init_at(logic [7:0] a);
        return dword_byte(a, OFS_IDS,      {DEVICE_ID, VENDOR_ID})
             | dword_byte(a, OFS_CMD,      {STATUS_RESET, CMD_RESET})
             | dword_byte(a, OFS_CLASS,    CLASS_REV)
             | dword_byte(a, OFS_WIN0,     WIN0_INIT)
             | dword_byte(a, OFS_WIN1,     WIN1_INIT)
             | dword_byte(a, OFS_IRQ_LINE, 32'h0000_00FF);
    endfunction

    logic [7:0] cur_mask, merged;

    assign cur_mask = mask_at(op.addr);
    assign merged   = (op.wdata & cur_mask) | (mem[op.addr] & ~cur_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SPACE_BYTES; i++)
                mem[i] <= init_at(8'(i));
        end else if (op.we) begin
            mem[op.addr] <= merged;
        end
    end

    assign rd_byte    = mem[op.addr];
    assign win0_value = {mem[OFS_WIN0 + 8'd3], mem[OFS_WIN0 + 8'd2],
                         mem[OFS_WIN0 + 8'd1], mem[OFS_WIN0]};

    // write history kept for the merge check
    logic       chk_we;
    logic [7:0] chk_addr, chk_old, chk_new, chk_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_we   <= 1'b0;
            chk_addr <= 8'h00;
            chk_old  <= 8'h00;
            chk_new  <= 8'h00;
            chk_mask <= 8'h00;
        end else begin
            chk_we   <= op.we;
            chk_addr <= op.addr;
            chk_old  <= mem[op.addr];
            chk_new  <= op.wdata;
            chk_mask <= cur_mask;
        end
    end

    AST_MASK_KEEP_OLD: assert property (@(posedge clk) disable iff (rst)
        chk_we |-> ((mem[chk_addr] & ~chk_mask) == (chk_old & ~chk_mask)));  // R1
    AST_MASK_TAKE_NEW: assert property (@(posedge clk) disable iff (rst)
        chk_we |-> ((mem[chk_addr] & chk_mask) == (chk_new & chk_mask)));    // R1
    AST_WIN0_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        win0_value[3:0] == 4'h8);                                             // R7

endmodule

// File: rtl/cfgsp_tick_ctr.sv
module cfgsp_tick_ctr
    import cfgsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic [7:0] addr,
    output logic       hit,
    output logic [7:0] rd_byte
);

    logic [TICK_W-1:0] up_q, dn_q, up_n, dn_n;
    logic              advance;
    logic [31:0]       shown;

    assign advance = rd_en && (addr == OFS_TICK);
    assign up_n    = up_q + TICK_W'(1);
    assign dn_n    = dn_q - TICK_W'(1);
    assign hit     = same_dword(addr, OFS_TICK);

    always_comb begin
        if (advance)
            shown = {4'h0, dn_n[DOWN_KEEP-1:0], up_n};
        else
            shown = {4'h0, dn_q[DOWN_KEEP-1:0], up_q};
    end

    assign rd_byte = lane_of(shown, addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= '0;
            dn_q <= '0;
        end else if (advance) begin
            up_q <= up_n;
            dn_q <= dn_n;
        end
    end

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        advance |=> (up_q == $past(up_q) + TICK_W'(1)) &&
                    (dn_q == $past(dn_q) - TICK_W'(1)));          // R10
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(up_q) && $stable(dn_q)));           // R11

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'hABCD,
    parameter logic [15:0] DEVICE_ID    = 16'h0042,
    parameter logic [15:0] CMD_RESET    = 16'h0002,
    parameter logic [15:0] CMD_MASK     = 16'h0403,
    parameter logic [15:0] STATUS_RESET = 16'h0080,
    parameter logic [31:0] CLASS_REV    = 32'h0400_0002,
    parameter logic [31:0] BAR0_BASE    = 32'hD000_0000,
    parameter logic [31:0] BAR0_MASK    = 32'hFF00_0000,
    parameter logic [31:0] BAR1_BASE    = 32'hE100_0000,
    parameter logic [31:0] BAR1_MASK    = 32'hFFFF_0000,
    parameter bit          HAS_TICK_CTR = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_valid,
    input  logic        cfg_write,
    input  logic [7:0]  cfg_reg,
    input  logic [1:0]  cfg_size,
    input  logic [31:0] cfg_wdata,
    output logic        cfg_busy,
    output logic        cfg_done,
    output logic [31:0] cfg_rdata,
    output logic        bar_upd,
    output logic [31:0] bar_base
);

    byte_op_t    op;
    logic [7:0]  op_rdata, store_byte, tick_byte;
    logic        tick_hit;
    logic [31:0] win0_value;

    cfgsp_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (cfg_valid),
        .acc_write  (cfg_write),
        .acc_reg    (cfg_reg),
        .acc_size   (cfg_size),
        .acc_wdata  (cfg_wdata),
        .op         (op),
        .op_rdata   (op_rdata),
        .busy       (cfg_busy),
        .done       (cfg_done),
        .rdata      (cfg_rdata),
        .win0_touch (bar_upd)
    );

    cfgsp_byte_store #(
        .VENDOR_ID    (VENDOR_ID),
        .DEVICE_ID    (DEVICE_ID),
        .CMD_RESET    (CMD_RESET),
        .CMD_MASK     (CMD_MASK),
        .STATUS_RESET (STATUS_RESET),
        .CLASS_REV    (CLASS_REV),
        .BAR0_BASE    (BAR0_BASE),
        .BAR0_MASK    (BAR0_MASK),
        .BAR1_BASE    (BAR1_BASE),
        .BAR1_MASK    (BAR1_MASK)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .rd_byte    (store_byte),
        .win0_value (win0_value)
    );

    generate
        if (HAS_TICK_CTR) begin : g_tick
            cfgsp_tick_ctr u_tick (
                .clk     (clk),
                .rst     (rst),
                .rd_en   (op.re),
                .addr    (op.addr),
                .hit     (tick_hit),
                .rd_byte (tick_byte)
            );
        end else begin : g_no_tick
            assign tick_hit  = 1'b0;
            assign tick_byte = 8'h00;
        end
    endgenerate

    assign op_rdata = tick_hit ? tick_byte : store_byte;
    assign bar_base = win0_value & 32'hFFFF_FFF0;

    AST_BAR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        bar_upd |-> cfg_done);                                     // R9
    AST_BAR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        bar_upd |-> ((bar_base & ~BAR0_MASK) == 32'h0));           // R7

endmodule

// File: tb/test_cfg_space_regfile.sv
module test_cfg_space_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_valid, cfg_write;
    logic [7:0]  cfg_reg;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic        cfg_busy, cfg_done, bar_upd;
    logic [31:0] cfg_rdata, bar_base;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    int exp_up = 0;
    int exp_dn = 0;

    always #2 clk = ~clk;   // 250 MHz

    cfg_space_regfile i_cfg_space_regfile (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_reg(cfg_reg), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_busy(cfg_busy), .cfg_done(cfg_done), .cfg_rdata(cfg_rdata),
        .bar_upd(bar_upd), .bar_base(bar_base)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // starts on a falling edge, returns on the falling edge where cfg_done is seen
    task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic barp);
        int lat;
        cfg_valid = 1'b1; cfg_write = wr; cfg_reg = a; cfg_size = sz; cfg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        lat = 0;
        while (!cfg_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R3 latency", lat, nbytes(sz));
        rd   = cfg_rdata;
        barp = bar_upd;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
        logic [31:0] r; logic b;
        access(1'b0, a, sz, 32'h0, r, b);
        chk(req, r, exp);
        chk({req, " no bar pulse on read"}, b, 1'b0);
    endtask

    task automatic wr_do(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd,
                         output logic barp);
        logic [31:0] r;
        access(1'b1, a, sz, wd, r, barp);
    endtask

    task automatic t_reset;
        chk("R3 reset busy", cfg_busy, 0);
        chk("R3 reset done", cfg_done, 0);
        chk("R9 reset pulse", bar_upd, 0);
        chk("R7 reset base", bar_base, 32'hD000_0000);
    endtask

    task automatic t_ids;
        logic b;
        rd_chk("R4 ids", 8'h00, 2'd2, 32'h0042_ABCD);
        wr_do(8'h00, 2'd2, 32'h1234_5678, b);
        rd_chk("R4 ids after write", 8'h00, 2'd2, 32'h0042_ABCD);
        rd_chk("R4 device word", 8'h02, 2'd1, 32'h0000_0042);
    endtask

    task automatic t_cmd;
        logic b;
        rd_chk("R5 cmd reset", 8'h04, 2'd1, 32'h0000_0002);
        wr_do(8'h04, 2'd1, 32'h0000_FFFF, b);
        rd_chk("R5 cmd all ones", 8'h04, 2'd1, 32'h0000_0403);
        wr_do(8'h04, 2'd1, 32'h0000_0000, b);
        rd_chk("R5 cmd zero", 8'h04, 2'd1, 32'h0000_0000);
        wr_do(8'h04, 2'd0, 32'h0000_00FE, b);
        rd_chk("R1 byte merge", 8'h04, 2'd0, 32'h0000_0002);
    endtask

    task automatic t_fixed;
        logic b;
        rd_chk("R6 status", 8'h06, 2'd1, 32'h0000_0080);
        wr_do(8'h06, 2'd1, 32'h0000_FFFF, b);
        rd_chk("R6 status ro", 8'h06, 2'd1, 32'h0000_0080);
        rd_chk("R6 irq line", 8'h3C, 2'd0, 32'h0000_00FF);
        wr_do(8'h3C, 2'd0, 32'h0000_0005, b);
        rd_chk("R6 irq line ro", 8'h3C, 2'd0, 32'h0000_00FF);
        rd_chk("R6 class", 8'h08, 2'd2, 32'h0400_0002);
        rd_chk("R2 straddle", 8'h06, 2'd2, 32'h0002_0080);
    endtask

    task automatic t_win0;
        logic b;
        rd_chk("R7 win0 reset", 8'h10, 2'd2, 32'hD000_0008);
        wr_do(8'h10, 2'd2, 32'hFFFF_FFFF, b);
        chk("R9 pulse dword", b, 1);
        chk("R9 base dword", bar_base, 32'hFF00_0000);
        rd_chk("R7 win0 ones", 8'h10, 2'd2, 32'hFF00_0008);
        wr_do(8'h10, 2'd2, 32'h1234_5678, b);
        chk("R9 base masked", bar_base, 32'h1200_0000);
        wr_do(8'h13, 2'd0, 32'h0000_00A5, b);
        chk("R9 pulse byte", b, 1);
        chk("R9 base byte", bar_base, 32'hA500_0000);
        wr_do(8'h10, 2'd0, 32'h0000_00FF, b);
        chk("R9 pulse low byte", b, 1);
        rd_chk("R7 low byte ro", 8'h10, 2'd2, 32'hA500_0008);
        wr_do(8'h04, 2'd0, 32'h0000_0002, b);
        chk("R9 no pulse elsewhere", b, 0);
    endtask

    task automatic t_win1;
        logic b;
        rd_chk("R8 win1 reset", 8'h14, 2'd2, 32'hE100_0000);
        wr_do(8'h14, 2'd2, 32'hFFFF_FFFF, b);
        chk("R9 no pulse win1", b, 0);
        rd_chk("R8 win1 ones", 8'h14, 2'd2, 32'hFFFF_0000);
        wr_do(8'h14, 2'd2, 32'h0000_0000, b);
        rd_chk("R8 win1 zero", 8'h14, 2'd2, 32'h0000_0000);
    endtask

    task automatic t_wrap_unimpl;
        logic b;
        rd_chk("R2 wrap", 8'hFE, 2'd2, 32'hABCD_0000);
        rd_chk("R2 size3 dword", 8'h00, 2'd3, 32'h0042_ABCD);
        wr_do(8'h80, 2'd2, 32'hDEAD_BEEF, b);
        rd_chk("R1 unimpl ro", 8'h80, 2'd2, 32'h0000_0000);
        rd_chk("R2 byte upper lanes", 8'h08, 2'd0, 32'h0000_0002);
    endtask

    function automatic logic [31:0] tick_val();
        return {4'h0, 12'(exp_dn), 16'(exp_up)};
    endfunction

    task automatic t_tick;
        logic b;
        logic [31:0] v;
        exp_up = exp_up + 1; exp_dn = (exp_dn - 1) & 16'hFFFF;
        rd_chk("R10 first low byte", 8'h54, 2'd0, {24'h0, 8'(exp_up)});
        exp_up = exp_up + 1; exp_dn = (exp_dn - 1) & 16'hFFFF;
        v = tick_val();
        rd_chk("R10 dword", 8'h54, 2'd2, v);
        rd_chk("R11 upper no advance", 8'h56, 2'd1, {16'h0, v[31:16]});
        rd_chk("R11 byte 55", 8'h55, 2'd0, {24'h0, v[15:8]});
        wr_do(8'h54, 2'd2, 32'hFFFF_FFFF, b);
        rd_chk("R11 write no effect", 8'h56, 2'd1, {16'h0, v[31:16]});
        exp_up = exp_up + 1; exp_dn = (exp_dn - 1) & 16'hFFFF;
        v = tick_val();
        rd_chk("R10 third", 8'h54, 2'd2, v);
        chk("R10 layout", v, 32'h0FFD_0003);
    endtask

    task automatic t_busy_ignore;
        int lat;
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_reg = 8'h00; cfg_size = 2'd2;
        cfg_wdata = 32'h0;
        @(posedge clk);
        @(negedge clk);
        chk("R3 busy after accept", cfg_busy, 1);
        cfg_write = 1'b1; cfg_reg = 8'h04; cfg_size = 2'd1; cfg_wdata = 32'h0000_0000;
        @(negedge clk);
        cfg_valid = 1'b0;
        lat = 1;
        while (!cfg_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R3 latency under stray strobe", lat, 4);
        chk("R3 data under stray strobe", cfg_rdata, 32'h0042_ABCD);
        rd_chk("R3 stray strobe ignored", 8'h04, 2'd1, 32'h0000_0002);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_valid = 1'b0; cfg_write = 1'b0;
        cfg_reg = 8'h00; cfg_size = 2'd0; cfg_wdata = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ids();
        t_cmd();
        t_fixed();
        t_win0();
        t_win1();
        t_wrap_unimpl();
        t_tick();
        t_busy_ignore();
        finish_run();
    end

endmodule